// File: doc/BRIEF.md
# Timer Match Output Pin Controller

This block drives the four match output levels of a timer. Each output has a two-bit action code in a 12-bit control register. When that output's match pulse arrives, the code decides whether the level is kept, driven low, driven high or inverted. The match comparators sit outside the block; it takes their single-cycle pulses and nothing else from them.

Software writes the low 12 bits of the register through a simple write strobe. It can preset the four output levels directly, and it reads back the current levels and action codes on a 32-bit readback bus. The upper readback bits always read as zero. The reset is asynchronous and active-low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `mpc_match_pins`

## Requirements
- R1: After reset, every output level and every action code reads 0, so `reg_rdata` is 0 and `match_out` is 0.
- R2: Action code 2'b00 (hold) leaves the output unchanged when its match pulse fires.
- R3: Action code 2'b01 (clear) drives the output to 0 when its match pulse fires.
- R4: Action code 2'b10 (set) drives the output to 1 when its match pulse fires.
- R5: Action code 2'b11 (toggle) inverts the output when its match pulse fires.
- R6: The action code for output n sits in register bits [5+2n:4+2n]. Output 0 uses 5:4, output 1 uses 7:6, output 2 uses 9:8 and output 3 uses 11:10.
- R7: Register bits 3:0 hold the levels of outputs 3..0. They appear on `match_out` and read back in `reg_rdata[3:0]`, and a register write loads them.
- R8: If a match pulse and a register write reach the same channel in the same cycle, the match action wins for that output level. The action used is the code held before that write, and the write still updates the action codes.
- R9: Readback bits 31:12 always read as 0.
- R10: Channels are independent. Match pulses on several channels in the same cycle are all applied on the same edge.
- R11: A match action or a register write takes effect on the first rising clock edge at which its pulse or strobe is sampled high. With no pulse and no write, all state is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised release |
| match_pulse | input | 4 | Single-cycle match event per output |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 12 | Write data: action codes in bits 11:4, output levels in bits 3:0 |
| reg_rdata | output | 32 | Register readback |
| match_out | output | 4 | Match output pin levels |

## Verification
A table of vectors loads different mixes of action codes into the channels. It then fires match pulses on one channel, on several channels and on all four at once. This separates each code's effect and shows that each field is decoded from its own bit positions. Toggle is applied twice, from different starting levels, so that toggle cannot be confused with set or clear. Vectors that combine a write with a match pulse show that the match wins over the preset level and that it uses the old action code. Directed tests cover reset values, stability when idle, zeros in the reserved readback bits and a reset in the middle of a run.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_CLEAR  = 2'b01,
    ACT_SET    = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;
endpackage

// File: rtl/mpc_rst_sync.sv
module mpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/mpc_ctrl_reg.sv
module mpc_ctrl_reg #(
  parameter int NUM_CH = 4,
  parameter int ACT_W  = 2,
  localparam int CTRL_W = NUM_CH * ACT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_fields,
  output logic [CTRL_W-1:0] fields
);
  logic [CTRL_W-1:0] fields_d;
  logic [CTRL_W-1:0] fields_q;

  always_comb begin
    fields_d = fields_q;
    if (wr_en) fields_d = wr_fields;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fields_q <= '0;
    else if (wr_en) fields_q <= fields_d;
  end

  assign fields = fields_q;

  // R7
  field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> fields == $past(wr_fields));
  // R11
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(fields));
endmodule

// File: rtl/mpc_pin_chan.sv
module mpc_pin_chan
  import mpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  act_e act,
  input  logic wr_en,
  input  logic wr_bit,
  output logic pin
);
  logic pin_q;
  logic pin_d;
  logic pin_en;

  always_comb begin
    pin_d = pin_q;
    if (match) begin
      unique case (act)
        ACT_HOLD:   pin_d = pin_q;
        ACT_CLEAR:  pin_d = 1'b0;
        ACT_SET:    pin_d = 1'b1;
        ACT_TOGGLE: pin_d = ~pin_q;
      endcase
    end else if (wr_en) begin
      pin_d = wr_bit;
    end
  end

  assign pin_en = match | wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (pin_en) pin_q <= pin_d;
  end

  assign pin = pin_q;

  // R2
  hold_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == ACT_HOLD) |=> $stable(pin));
  // R3
  clear_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == ACT_CLEAR) |=> !pin);
  // R4
  set_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == ACT_SET) |=> pin);
  // R5
  toggle_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == ACT_TOGGLE) |=> pin != $past(pin));
  // R7
  preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && wr_en) |=> pin == $past(wr_bit));
  // R11
  idle_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && !wr_en) |=> $stable(pin));
endmodule

// File: rtl/mpc_match_pins.sv
module mpc_match_pins
  import mpc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ACT_W  = 2,
  parameter int RD_W   = 32,
  localparam int CTRL_W = NUM_CH * ACT_W,
  localparam int REG_W  = NUM_CH + CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] match_pulse,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [RD_W-1:0]   reg_rdata,
  output logic [NUM_CH-1:0] match_out
);
  logic              rst_n_s;
  logic [CTRL_W-1:0] ctrl_fields;
  logic [NUM_CH-1:0] pins;

  mpc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  mpc_ctrl_reg #(.NUM_CH(NUM_CH), .ACT_W(ACT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (reg_we),
    .wr_fields (reg_wdata[REG_W-1:NUM_CH]),
    .fields    (ctrl_fields)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    mpc_pin_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .match  (match_pulse[ch]),
      .act    (act_e'(ctrl_fields[ch*ACT_W +: ACT_W])),
      .wr_en  (reg_we),
      .wr_bit (reg_wdata[ch]),
      .pin    (pins[ch])
    );
  end

  assign match_out = pins;

  always_comb begin
    reg_rdata = '0;
    reg_rdata[REG_W-1:0] = {ctrl_fields, pins};
  end

  // R8
  write_fields_prio_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_we && (match_pulse != '0)) |=> reg_rdata[REG_W-1:NUM_CH] == $past(reg_wdata[REG_W-1:NUM_CH]));
endmodule

// File: tb/tb_mpc_match_pins.sv
`timescale 1ns/1ps
module tb_mpc_match_pins;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  match_pulse;
  logic        reg_we;
  logic [11:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  match_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mpc_match_pins dut (
    .clk(clk), .rst_n(rst_n), .match_pulse(match_pulse), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match_out(match_out)
  );

  // entry: {we, wdata[11:0], match[3:0], expected rdata[11:0], tag[3:0]}
  localparam int NV = 13;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 12'h362, 4'h0, 12'h362, 4'd7},   // R7 preset levels, load codes
    {1'b0, 12'h000, 4'hF, 12'h365, 4'd10},  // R10 all four apply together
    {1'b0, 12'h000, 4'h4, 12'h361, 4'd5},   // R5 toggle 1 -> 0
    {1'b1, 12'h36F, 4'h2, 12'h36D, 4'd8},   // R8 clear wins over preset 1
    {1'b1, 12'hFF0, 4'h8, 12'hFF8, 4'd8},   // R8 old hold code used
    {1'b0, 12'h000, 4'hF, 12'hFF7, 4'd5},   // R5 toggle all
    {1'b0, 12'h000, 4'h0, 12'hFF7, 4'd11},  // R11 idle stable
    {1'b1, 12'h00A, 4'h0, 12'h00A, 4'd7},   // R7 preset 1010
    {1'b0, 12'h000, 4'hF, 12'h00A, 4'd2},   // R2 hold all
    {1'b1, 12'h55F, 4'h0, 12'h55F, 4'd6},   // R6 clear codes at each field
    {1'b0, 12'h000, 4'h5, 12'h55A, 4'd3},   // R3 clear ch0, ch2
    {1'b1, 12'hAA0, 4'h0, 12'hAA0, 4'd6},   // R6 set codes at each field
    {1'b0, 12'h000, 4'h9, 12'hAA9, 4'd4}    // R4 set ch0, ch3
  };

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      finish_run();
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    match_pulse = '0;
    reg_we = 1'b0;
    reg_wdata = '0;
    do_reset();
    // R1 reset state
    check("R1", reg_rdata, 32'h0);
    check("R1", {28'h0, match_out}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      reg_we      = VEC[i][32];
      reg_wdata   = VEC[i][31:20];
      match_pulse = VEC[i][19:16];
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0; match_pulse = '0;
      check(tag_name(int'(VEC[i][3:0])), reg_rdata, {20'h0, VEC[i][15:4]});
      // R7 pins follow readback bits 3:0
      check("R7", {28'h0, match_out}, {28'h0, VEC[i][7:4]});
    end

    // R9 reserved readback zero with all bits written to ones
    reg_we = 1'b1; reg_wdata = 12'hFFF;
    @(negedge clk);
    reg_we = 1'b0;
    check("R9", reg_rdata, 32'h0000_0FFF);

    // R11 no change without an edge carrying a pulse or strobe
    match_pulse = 4'hF;
    #1;
    check("R11", reg_rdata, 32'h0000_0FFF);
    @(negedge clk);
    match_pulse = '0;
    check("R11", reg_rdata, 32'h0000_0FF0);

    // R1 reset mid-run clears everything
    do_reset();
    check("R1", reg_rdata, 32'h0);
    check("R1", {28'h0, match_out}, 32'h0);

    finish_run();
  end
endmodule